// File: doc/BRIEF.md
# Arithmetic Logic Unit with Status Flags

This block is an n-bit combinational arithmetic logic unit (8 bits by default) paired with a small clocked status register. Every operation, arithmetic or logic, comes out of one ripple-carry chain of full adders. Each bit slice feeds its adder with three inputs derived from the operands and the function select. In arithmetic mode the first input is the A bit, the second input is a selected form of B, and the carry ripples normally. In logic mode the carry into every slice is held at zero, so the sum bit reduces to the exclusive-OR of the two adder inputs. The first input is then modified with B or its complement so that this exclusive-OR yields OR and AND.

The result is available at the output in the same cycle. The carry, zero, sign and overflow flags are formed from the result and from the chain's last two carries. They are loaded into the status register on a rising clock edge when the update enable is high. A controller compares two values by subtracting them and reading the zero and carry flags.

Top module: `alu_flags_top`

## Requirements
- R1: With sel_i[2]=0 the result (mod 2^W) for {sel_i[1:0],cin_i} is as follows. 000 gives A. 001 gives A+1. 010 gives A+B. 011 gives A+B+1. 100 gives A+~B. 101 gives A-B. 110 gives A-1. 111 gives A.
- R2: sel_i=3'b100 gives A|B, whatever the value of cin_i.
- R3: Whatever the value of cin_i, sel_i=3'b101 gives A^B, sel_i=3'b110 gives A&B, and sel_i=3'b111 gives ~A.
- R4: flags_o packs {C,Z,S,V} in bits 3,2,1,0. In arithmetic mode C is the carry out of the top bit of the operation in R1; in logic mode C is 0.
- R5: Z is 1 exactly when the W result bits are all zero.
- R6: S equals the result's most significant bit.
- R7: In arithmetic mode V is the carry into the top bit XOR the carry out of it, so that a signed result outside the W-bit range sets V. In logic mode V is 0.
- R8: flags_o is loaded with the flags of the current inputs on a rising clk_i edge with flag_we_i=1. On an edge with flag_we_i=0 it keeps its value.
- R9: While rst_ni is low, flags_o is 0000 whatever the value of flag_we_i.
- R10: After A-B (sel_i=3'b010, cin_i=1), Z=1 exactly when A equals B, and C=1 exactly when A is at least B as unsigned values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the status register |
| rst_ni | input | 1 | Asynchronous active-low reset of the flags |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| sel_i | input | 3 | Function select; bit 2 picks logic mode |
| cin_i | input | 1 | Carry in, used in arithmetic mode only |
| flag_we_i | input | 1 | Load enable for the status register |
| result_o | output | W | Combinational result |
| flags_o | output | 4 | Registered {C,Z,S,V} |

## Verification
The operand forming and the carry chain have no state, so a wrong X, Y or carry term shows on result_o in the same cycle as the inputs that expose it. The only state is the status register. A wrong flag term, or a load on an edge that should not load, shows on flags_o one edge after the update. Overflow and carry are exercised at the signed and unsigned limits, where an error in a single carry changes the value of the flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu_operand_gen.sv
module alu_operand_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o
);
  logic s2, s1, s0;
  assign {s2, s1, s0} = sel_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    // X is widened with B (OR) or B' (AND) only in logic mode
    assign x_o[i] = a_i[i] | (s2 & ~s1 & ~s0 & b_i[i]) | (s2 & s1 & ~s0 & ~b_i[i]);
    assign y_o[i] = (s0 & b_i[i]) | (s1 & ~b_i[i]);
  end
endmodule

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  input  logic         carry_en_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         cout_o
);
  logic [W:0]   c;
  logic [W-1:0] z;

  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign z[i]   = carry_en_i & c[i];
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ z[i];
    assign c[i+1] = (x_i[i] & y_i[i]) | ((x_i[i] ^ y_i[i]) & z[i]);
  end

  assign c_msb_o = z[W-1];
  assign cout_o  = c[W];

  always_comb begin
    if (carry_en_i === 1'b1 && !$isunknown({x_i, y_i, cin_i})) begin
      assert_chain_sum_R1: assert ({cout_o, sum_o} ==
        ({1'b0, x_i} + {1'b0, y_i} + (W+1)'(cin_i)))
        else $error("carry chain sum mismatch");
    end
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   sel_i,
  input  logic         cin_i,
  input  logic         flag_we_i,
  output logic [W-1:0] result_o,
  output logic [3:0]   flags_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y, sum;
  logic         c_msb, cout, arith;
  flags_t       nxt, cur;

  assign arith = ~sel_i[2];

  alu_operand_gen #(.W(W)) u_opgen (
    .a_i(a_i), .b_i(b_i), .sel_i(sel_i), .x_o(x), .y_o(y)
  );

  alu_ripple #(.W(W)) u_chain (
    .x_i(x), .y_i(y), .cin_i(cin_i), .carry_en_i(arith),
    .sum_o(sum), .c_msb_o(c_msb), .cout_o(cout)
  );

  assign result_o = sum;
  assign nxt.c = arith & cout;
  assign nxt.z = ~|sum;
  assign nxt.s = sum[MSB];
  assign nxt.v = arith & (c_msb ^ cout);

  alu_status_reg u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(flag_we_i), .d_i(nxt), .q_o(cur)
  );

  assign flags_o = cur;

  assert_logic_no_cv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && sel_i[2]) |=> (!flags_o[3] && !flags_o[0]));
  assert_zero_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (flags_o[2] == ($past(result_o) == '0)));
  assert_sign_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (flags_o[1] == $past(result_o[MSB])));
  assert_logic_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && sel_i[2]) |=> !flags_o[0]);
endmodule

// File: tb/sim_alu_flags_top.sv
module sim_alu_flags_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [2:0]   sel = '0;
  logic         cin = 1'b0, we = 1'b0;
  logic [W-1:0] result;
  logic [3:0]   flags;

  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_flags = 4'b0000;
  bit done = 1'b0;

  always #5 clk = ~clk;

  alu_flags_top #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_i(a), .b_i(b), .sel_i(sel),
    .cin_i(cin), .flag_we_i(we), .result_o(result), .flags_o(flags)
  );

  // returns {C,Z,S,V,result}
  function automatic logic [W+3:0] model(logic [W-1:0] ma, logic [W-1:0] mb,
                                         logic [2:0] ms, logic mc);
    logic [W-1:0] yv, r;
    logic [W:0]   full;
    logic [W-1:0] low;
    logic c, v;
    c = 1'b0; v = 1'b0; yv = '0;
    if (!ms[2]) begin
      case (ms[1:0])
        2'b00: yv = '0;
        2'b01: yv = mb;
        2'b10: yv = ~mb;
        default: yv = '1;
      endcase
      full = {1'b0, ma} + {1'b0, yv} + (W+1)'(mc);
      r = full[W-1:0];
      c = full[W];
      low = {1'b0, ma[W-2:0]} + {1'b0, yv[W-2:0]} + W'(mc);
      v = low[W-1] ^ c;
    end else begin
      case (ms[1:0])
        2'b00: r = ma | mb;
        2'b01: r = ma ^ mb;
        2'b10: r = ma & mb;
        default: r = ~ma;
      endcase
    end
    return {c, (r == '0), r[W-1], v, r};
  endfunction

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one vector, check result in-cycle and flags after the edge
  task automatic apply(logic [W-1:0] ta, logic [W-1:0] tb, logic [2:0] ts,
                       logic tc, logic twe, string rtag);
    logic [W+3:0] m;
    @(negedge clk);
    a = ta; b = tb; sel = ts; cin = tc; we = twe;
    #1;
    m = model(ta, tb, ts, tc);
    chk(result == m[W-1:0], rtag, result, m[W-1:0]);
    if (twe) exp_flags = m[W+3:W];
    @(negedge clk);
    we = 1'b0;
    chk(flags[3] == exp_flags[3], "R4 C flag", W'(flags[3]), W'(exp_flags[3]));
    chk(flags[2] == exp_flags[2], "R5 Z flag", W'(flags[2]), W'(exp_flags[2]));
    chk(flags[1] == exp_flags[1], "R6 S flag", W'(flags[1]), W'(exp_flags[1]));
    chk(flags[0] == exp_flags[0], "R7 V flag", W'(flags[0]), W'(exp_flags[0]));
  endtask

  task automatic t_reset();
    a = '0; sel = 3'b000; we = 1'b1;
    repeat (3) @(negedge clk);
    chk(flags == 4'b0000, "R9 reset flags", W'(flags), '0);
    rst_ni = 1'b1;
    we = 1'b0;
    @(negedge clk);
    chk(flags == 4'b0000, "R9 flags after release", W'(flags), '0);
  endtask

  task automatic t_arith();
    logic [W-1:0] va [6] = '{8'h00, 8'h3c, 8'hff, 8'h80, 8'h7f, 8'h55};
    logic [W-1:0] vb [6] = '{8'h00, 8'h21, 8'h01, 8'h80, 8'h01, 8'haa};
    for (int p = 0; p < 6; p++)
      for (int code = 0; code < 8; code++)
        apply(va[p], vb[p], {1'b0, 2'(code >> 1)}, code[0], 1'b1, "R1 arith");
  endtask

  task automatic t_logic();
    for (int code = 4; code < 8; code++)
      for (int c = 0; c < 2; c++) begin
        apply(8'hc5, 8'h3a, 3'(code), c[0], 1'b1, code == 4 ? "R2 or" : "R3 logic");
        apply(8'hf0, 8'h0f, 3'(code), c[0], 1'b1, code == 4 ? "R2 or" : "R3 logic");
        apply(8'h00, 8'h00, 3'(code), c[0], 1'b1, code == 4 ? "R2 or" : "R3 logic");
      end
  endtask

  task automatic t_hold();
    apply(8'hff, 8'h01, 3'b001, 1'b0, 1'b1, "R8 load");  // C=1 Z=1
    apply(8'h12, 8'h34, 3'b001, 1'b0, 1'b0, "R8 hold");
    chk(flags == 4'b1100, "R8 flags held", W'(flags), W'(4'b1100));
    apply(8'h80, 8'h00, 3'b101, 1'b0, 1'b0, "R8 hold");
    chk(flags == 4'b1100, "R8 flags held", W'(flags), W'(4'b1100));
  endtask

  task automatic t_compare();
    logic [W-1:0] ca [5] = '{8'h42, 8'h43, 8'h41, 8'h00, 8'hff};
    logic [W-1:0] cb [5] = '{8'h42, 8'h42, 8'h42, 8'hff, 8'h00};
    for (int p = 0; p < 5; p++) begin
      apply(ca[p], cb[p], 3'b010, 1'b1, 1'b1, "R10 subtract");
      chk(flags[2] == (ca[p] == cb[p]), "R10 equal", W'(flags[2]), W'(ca[p] == cb[p]));
      chk(flags[3] == (ca[p] >= cb[p]), "R10 unsigned ge", W'(flags[3]), W'(ca[p] >= cb[p]));
    end
  endtask

  task automatic t_overflow();
    apply(8'h7f, 8'h00, 3'b000, 1'b1, 1'b1, "R7 inc overflow");
    chk(flags == 4'b0011, "R7 7f+1 flags", W'(flags), W'(4'b0011));
    apply(8'h80, 8'h00, 3'b011, 1'b0, 1'b1, "R7 dec overflow");
    chk(flags == 4'b1001, "R7 80-1 flags", W'(flags), W'(4'b1001));
    apply(8'hff, 8'h00, 3'b000, 1'b1, 1'b1, "R4 inc wrap");
    chk(flags == 4'b1100, "R4 ff+1 flags", W'(flags), W'(4'b1100));
    apply(8'h80, 8'h7f, 3'b010, 1'b1, 1'b1, "R7 sub overflow");
    chk(flags[0] == 1'b1, "R7 80-7f V", W'(flags[0]), W'(1'b1));
  endtask

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_hold();
    t_compare();
    t_overflow();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R8: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule